// File: doc/BRIEF.md
# Handshake Side-Channel Updater and Router

This block carries three slow side channels (request-to-send, terminal-ready and a ring indicator) across a link that moves data in bursts. On the send side it decides when a fresh three-bit snapshot of the local inputs has to be queued for the next burst. A snapshot is requested by any edge on the request-to-send or terminal-ready input, or by a free-running refresh timer that fires about every 1.6 ms. A two-bit bandwidth setting sets a minimum spacing between snapshots. A request that arrives inside that spacing is held back and sent when the spacing ends, and the snapshot then carries the inputs as they are at that moment. The snapshot goes out on a valid/ready port toward the burst queue.

On the receive side the block takes the far-end snapshot from a valid strobe and routes its three bits to the local clear-to-send, set-ready and ring outputs. A local loopback input replaces the far-end values with the local inputs, and the received serial data with the local transmit data. A remote loopback request is passed on only when local loopback is not also requested. While the link is not locked and local loopback is off, the outputs sit at safe levels: clear-to-send and set-ready high, ring low and received data low.

Top module: `hs_side_chan`

## Requirements
- R1: While reset is held and on the first cycle after it, snap_valid is low, cts_out and dsr_out are high, and rio_out and rxd_out are low.
- R2: A change on rts_in or dtr_in, when the spacing has run out and the snapshot slot is free, raises snap_valid at the very next clock edge. snap_data then holds bit 0 = rts_in, bit 1 = dtr_in and bit 2 = ring_in, as sampled at that edge.
- R3: A change on ring_in alone requests no snapshot. The new ring value goes out with the next timer-driven snapshot.
- R4: With no other requests and snap_ready high, a snapshot is issued exactly UPD_PERIOD clocks (default CLK_HZ/625) after the previous one. The refresh timer restarts on every issued snapshot.
- R5: Two snapshots are never issued less than the spacing apart. The spacing is set by bw_sel, rounded to whole clocks: 01 gives CLK_HZ/10000, 10 gives CLK_HZ/5000, 11 gives CLK_HZ/2500 and 00 gives CLK_HZ/600. A change held back by the spacing is issued exactly when the spacing ends and carries the input values of that clock edge.
- R6: super_cmp is high exactly when bw_sel is 00, in the same cycle.
- R7: While snap_valid is high and snap_ready is low, snap_valid stays high and snap_data does not change.
- R8: When the link is locked and local loopback is off, cts_out, dsr_out and rio_out show bits 0, 1 and 2 of the most recent far_data accepted with far_valid, one clock after acceptance. rxd_out follows rxd_line one clock later.
- R9: With loop_local high, whether or not the link is locked, cts_out, dsr_out and rio_out follow rts_in, dtr_in and ring_in one clock later, and rxd_out follows txd_in. Far-end values have no effect on these outputs.
- R10: remote_loop_out equals loop_remote AND NOT loop_local, in the same cycle.
- R11: With link_locked low and loop_local low, the next clock edge drives cts_out and dsr_out high and rio_out and rxd_out low, whatever the far-end inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rts_in | input | 1 | Local request-to-send (synchronous) |
| dtr_in | input | 1 | Local terminal-ready (synchronous) |
| ring_in | input | 1 | Local ring indicator (synchronous) |
| txd_in | input | 1 | Local transmit data, used for local loopback |
| bw_sel | input | 2 | Side-channel bandwidth select (spacing) |
| snap_valid | output | 1 | Snapshot waiting for the burst queue |
| snap_ready | input | 1 | Burst queue accepts the snapshot |
| snap_data | output | 3 | Snapshot: bit0 rts, bit1 dtr, bit2 ring |
| far_valid | input | 1 | Far-end snapshot strobe |
| far_data | input | 3 | Far-end snapshot, same bit order |
| rxd_line | input | 1 | Received serial data from the link |
| link_locked | input | 1 | Link synchronised |
| loop_local | input | 1 | Local loopback request |
| loop_remote | input | 1 | Remote loopback request |
| cts_out | output | 1 | Local clear-to-send |
| dsr_out | output | 1 | Local set-ready |
| rio_out | output | 1 | Local ring output |
| rxd_out | output | 1 | Received data output |
| remote_loop_out | output | 1 | Granted remote loopback request |
| super_cmp | output | 1 | Super-compress flag (bw_sel = 00) |

## Verification
A snapshot is due one edge after an rts or dtr change when the slot is free. A held-back change is due exactly the spacing after the previous snapshot, and a timer snapshot exactly the refresh period after it. The router outputs change one edge after their inputs, while super_cmp and remote_loop_out are combinational. The bench drives every input on a falling edge and samples on a later falling edge. It keeps a counter of rising edges, so each spacing or period is checked as an exact cycle distance between two observed snapshots.

// File: rtl/hs_side_pkg.sv
package hs_side_pkg;

   // Bit order shared by the outgoing and incoming snapshots.
   typedef struct packed {
      logic ring;
      logic dtr;
      logic rts;
   } hs_snap_t;

   localparam int unsigned HS_CHANS = 3;

   // Safe levels while unlocked: bit0 cts high, bit1 dsr high, bit2 ring low.
   localparam logic [HS_CHANS-1:0] HS_SAFE_LVL = 3'b011;

   typedef enum logic [1:0] {
      BW_600  = 2'b00,
      BW_10K  = 2'b01,
      BW_5K   = 2'b10,
      BW_2K5  = 2'b11
   } hs_bw_e;

   function automatic int unsigned div_round(input int unsigned num, input int unsigned den);
      return (num + den / 2) / den;
   endfunction

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/hs_gap_timer.sv
module hs_gap_timer
   import hs_side_pkg::*;
#(
   parameter int unsigned CW  = 15,
   parameter int unsigned G00 = 16667,
   parameter int unsigned G01 = 1000,
   parameter int unsigned G10 = 2000,
   parameter int unsigned G11 = 4000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [1:0]    sel,
   output logic          open,
   output logic [CW-1:0] span
);

   logic [CW-1:0] cnt_q;

   always_comb begin
      case (hs_bw_e'(sel))
         BW_10K:  span = CW'(G01);
         BW_5K:   span = CW'(G10);
         BW_2K5:  span = CW'(G11);
         default: span = CW'(G00);
      endcase
   end

   assign open = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (load)    cnt_q <= span - CW'(1);
      else if (!open)   cnt_q <= cnt_q - CW'(1);
   end

   assert_gap_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q < span + CW'(1)) || $changed(sel));

endmodule

// File: rtl/hs_period_timer.sv
module hs_period_timer #(
   parameter int unsigned PERIOD = 16000,
   localparam int unsigned PW    = (PERIOD > 2) ? $clog2(PERIOD) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic due
);

   logic [PW-1:0] cnt_q;

   assign due = (cnt_q == PW'(PERIOD - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt_q <= '0;
      else if (restart)  cnt_q <= '0;
      else if (!due)     cnt_q <= cnt_q + PW'(1);
   end

   assert_period_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (due && !restart) |=> due);

endmodule

// File: rtl/hs_rx_router.sv
module hs_rx_router
   import hs_side_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     locked,
   input  logic     loop_local,
   input  hs_snap_t loc_snap,
   input  logic     txd,
   input  logic     far_valid,
   input  hs_snap_t far_snap,
   input  logic     rxd_line,
   output logic     cts,
   output logic     dsr,
   output logic     rio,
   output logic     rxd
);

   hs_snap_t              far_q;
   logic [HS_CHANS-1:0]   far_now;
   logic [HS_CHANS-1:0]   out_q;
   logic                  rxd_q;

   always_ff @(posedge clk) begin
      if (!rst_n)         far_q <= '0;
      else if (far_valid) far_q <= far_snap;
   end

   assign far_now = far_valid ? far_snap : far_q;

   for (genvar g = 0; g < HS_CHANS; g++) begin : g_chan
      logic pick;
      assign pick = loop_local ? loc_snap[g] : far_now[g];
      always_ff @(posedge clk) begin
         if (!rst_n)                     out_q[g] <= HS_SAFE_LVL[g];
         else if (loop_local || locked)  out_q[g] <= pick;
         else                            out_q[g] <= HS_SAFE_LVL[g];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)           rxd_q <= 1'b0;
      else if (loop_local)  rxd_q <= txd;
      else if (locked)      rxd_q <= rxd_line;
      else                  rxd_q <= 1'b0;
   end

   assign cts = out_q[0];
   assign dsr = out_q[1];
   assign rio = out_q[2];
   assign rxd = rxd_q;

   assert_unlock_safe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!locked && !loop_local) |=> (cts && dsr && !rio && !rxd));

   assert_local_loop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      loop_local |=> ({rio, dsr, cts} == $past(loc_snap)) && (rxd == $past(txd)));

   assert_far_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !loop_local && far_valid) |=> ({rio, dsr, cts} == $past(far_snap)));

endmodule

// File: rtl/hs_side_chan.sv
module hs_side_chan
   import hs_side_pkg::*;
#(
   parameter int unsigned CLK_HZ     = 10_000_000,
   parameter int unsigned UPD_PERIOD = CLK_HZ / 625
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rts_in,
   input  logic       dtr_in,
   input  logic       ring_in,
   input  logic       txd_in,
   input  logic [1:0] bw_sel,
   output logic       snap_valid,
   input  logic       snap_ready,
   output logic [2:0] snap_data,
   input  logic       far_valid,
   input  logic [2:0] far_data,
   input  logic       rxd_line,
   input  logic       link_locked,
   input  logic       loop_local,
   input  logic       loop_remote,
   output logic       cts_out,
   output logic       dsr_out,
   output logic       rio_out,
   output logic       rxd_out,
   output logic       remote_loop_out,
   output logic       super_cmp
);

   localparam int unsigned G00  = div_round(CLK_HZ, 600);
   localparam int unsigned G01  = div_round(CLK_HZ, 10000);
   localparam int unsigned G10  = div_round(CLK_HZ, 5000);
   localparam int unsigned G11  = div_round(CLK_HZ, 2500);
   localparam int unsigned GMAX = max4(G00, G01, G10, G11);
   localparam int unsigned CW   = $clog2(GMAX + 1);

   if (CLK_HZ < 20000) begin : g_bad_clk
      $error("hs_side_chan: CLK_HZ too low for a two-clock minimum spacing");
   end
   if (UPD_PERIOD < 2) begin : g_bad_period
      $error("hs_side_chan: UPD_PERIOD must be at least 2");
   end

   hs_snap_t       loc_snap;
   logic           rts_q, dtr_q;
   logic           chg, pend_q, due, gap_open, slot_free, req, issue;
   logic [CW-1:0]  span;

   assign loc_snap = '{ring: ring_in, dtr: dtr_in, rts: rts_in};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rts_q <= 1'b0;
         dtr_q <= 1'b0;
      end else begin
         rts_q <= rts_in;
         dtr_q <= dtr_in;
      end
   end

   assign chg       = (rts_in ^ rts_q) | (dtr_in ^ dtr_q);
   assign req       = pend_q | chg | due;
   assign slot_free = !snap_valid || snap_ready;
   assign issue     = req && gap_open && slot_free;

   always_ff @(posedge clk) begin
      if (!rst_n)      pend_q <= 1'b0;
      else if (issue)  pend_q <= 1'b0;
      else if (req)    pend_q <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap_valid <= 1'b0;
         snap_data  <= '0;
      end else if (issue) begin
         snap_valid <= 1'b1;
         snap_data  <= loc_snap;
      end else if (snap_ready) begin
         snap_valid <= 1'b0;
      end
   end

   hs_gap_timer #(
      .CW  (CW),
      .G00 (G00),
      .G01 (G01),
      .G10 (G10),
      .G11 (G11)
   ) u_gap (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (issue),
      .sel   (bw_sel),
      .open  (gap_open),
      .span  (span)
   );

   hs_period_timer #(
      .PERIOD (UPD_PERIOD)
   ) u_period (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (issue),
      .due     (due)
   );

   hs_rx_router u_router (
      .clk        (clk),
      .rst_n      (rst_n),
      .locked     (link_locked),
      .loop_local (loop_local),
      .loc_snap   (loc_snap),
      .txd        (txd_in),
      .far_valid  (far_valid),
      .far_snap   (hs_snap_t'(far_data)),
      .rxd_line   (rxd_line),
      .cts        (cts_out),
      .dsr        (dsr_out),
      .rio        (rio_out),
      .rxd        (rxd_out)
   );

   assign remote_loop_out = loop_remote & ~loop_local;
   assign super_cmp       = (hs_bw_e'(bw_sel) == BW_600);

   // Checker state: distance since the last snapshot and the spacing it set.
   logic [CW-1:0] since_q, last_gap_q;
   logic          seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_q    <= '0;
         last_gap_q <= '0;
         seen_q     <= 1'b0;
      end else if (issue) begin
         since_q    <= '0;
         last_gap_q <= span;
         seen_q     <= 1'b1;
      end else if (since_q != {CW{1'b1}}) begin
         since_q    <= since_q + CW'(1);
      end
   end

   assert_min_space_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && seen_q) |-> (since_q >= last_gap_q - CW'(1)));

   assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (snap_valid && !snap_ready) |=> (snap_valid && $stable(snap_data)));

endmodule

// File: tb/tb_hs_side_chan.sv
module tb_hs_side_chan;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rts_in = 0, dtr_in = 0, ring_in = 0, txd_in = 0;
   logic [1:0] bw_sel = 2'b01;
   logic       snap_valid;
   logic       snap_ready = 1'b1;
   logic [2:0] snap_data;
   logic       far_valid = 0;
   logic [2:0] far_data = '0;
   logic       rxd_line = 0, link_locked = 0, loop_local = 0, loop_remote = 0;
   logic       cts_out, dsr_out, rio_out, rxd_out, remote_loop_out, super_cmp;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit done  = 0;

   hs_side_chan #(.CLK_HZ(100000)) dut (
      .clk(clk), .rst_n(rst_n), .rts_in(rts_in), .dtr_in(dtr_in), .ring_in(ring_in),
      .txd_in(txd_in), .bw_sel(bw_sel), .snap_valid(snap_valid), .snap_ready(snap_ready),
      .snap_data(snap_data), .far_valid(far_valid), .far_data(far_data),
      .rxd_line(rxd_line), .link_locked(link_locked), .loop_local(loop_local),
      .loop_remote(loop_remote), .cts_out(cts_out), .dsr_out(dsr_out), .rio_out(rio_out),
      .rxd_out(rxd_out), .remote_loop_out(remote_loop_out), .super_cmp(super_cmp)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // Router vectors: inputs {lock, lloop, rloop, rts, dtr, ring, txd, fv, fd[2:0], rxd_line},
   // expected {cts, dsr, rio, rxd, remote_loop}.
   localparam logic [16:0] VEC [8] = '{
      {12'b000000011011, 5'b11000},
      {12'b100000000001, 5'b10110},
      {12'b100111110100, 5'b01000},
      {12'b111101111110, 5'b10110},
      {12'b101010000001, 5'b11111},
      {12'b010011000001, 5'b01100},
      {12'b001111100001, 5'b11001},
      {12'b100000010001, 5'b00010}
   };

   localparam logic [1:0] SEL_T [4] = '{2'b01, 2'b10, 2'b11, 2'b00};
   localparam int         GAP_T [4] = '{10, 20, 40, 167};
   localparam int         PERIOD    = 160;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_issue(output int c, output logic [2:0] d);
      bit got = 0;
      c = 0;
      d = '0;
      for (int k = 0; k < 1000; k++) begin
         @(negedge clk);
         if (snap_valid) begin
            c = cyc;
            d = snap_data;
            got = 1;
            break;
         end
      end
      if (!got) chk("R4 snapshot timeout", 0, 1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      finish_run();
   end

   initial begin
      int c1, c2, x;
      logic [2:0] d;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 snap_valid", snap_valid, 0);
      chk("R1 cts", cts_out, 1);
      chk("R1 dsr", dsr_out, 1);
      chk("R1 rio", rio_out, 0);
      chk("R1 rxd", rxd_out, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", {snap_valid, cts_out, dsr_out, rio_out, rxd_out}, 5'b01100);

      // R8 R9 R10 R11: routing table
      for (int i = 0; i < 8; i++) begin
         {link_locked, loop_local, loop_remote, rts_in, dtr_in, ring_in, txd_in,
          far_valid, far_data, rxd_line} = VEC[i][16:5];
         @(negedge clk);
         chk($sformatf("R8 R9 R10 R11 router vector %0d", i),
             {cts_out, dsr_out, rio_out, rxd_out, remote_loop_out}, VEC[i][4:0]);
      end
      {link_locked, loop_local, loop_remote, rts_in, dtr_in, ring_in, txd_in,
       far_valid, far_data, rxd_line} = 12'b100000000000;

      // R4: refresh period between two quiet snapshots
      wait_issue(c1, d);
      wait_issue(c2, d);
      chk("R4 refresh period", c2 - c1, PERIOD);

      // R2: one-cycle latency for an rts edge
      repeat (30) @(negedge clk);
      rts_in = 1'b1;
      x = cyc;
      @(negedge clk);
      chk("R2 valid after edge", snap_valid, 1);
      chk("R2 latency", cyc, x + 1);
      chk("R2 data", snap_data, 3'b001);

      // R3: ring change alone waits for the timer
      c1 = cyc;
      @(negedge clk);
      ring_in = 1'b1;
      wait_issue(c2, d);
      chk("R3 ring waits for timer", c2 - c1, PERIOD);
      chk("R3 ring value carried", d, 3'b101);

      // R5 R6: spacing per bandwidth setting, held change carries latest values
      for (int i = 0; i < 4; i++) begin
         bw_sel = SEL_T[i];
         #1;
         chk($sformatf("R6 super flag sel %0d", SEL_T[i]), super_cmp, (SEL_T[i] == 2'b00));
         wait_issue(c1, d);
         @(negedge clk);
         rts_in = ~rts_in;
         @(negedge clk);
         dtr_in = ~dtr_in;
         wait_issue(c2, d);
         chk($sformatf("R5 spacing sel %0d", SEL_T[i]), c2 - c1, GAP_T[i]);
         chk($sformatf("R5 held data sel %0d", SEL_T[i]), d, {ring_in, dtr_in, rts_in});
      end

      // R7: stall holds the snapshot
      bw_sel = 2'b01;
      wait_issue(c1, d);
      repeat (20) @(negedge clk);
      snap_ready = 1'b0;
      rts_in = ~rts_in;
      @(negedge clk);
      chk("R7 valid on stall", snap_valid, 1);
      chk("R7 data on stall", snap_data, {ring_in, dtr_in, rts_in});
      begin
         int bad = 0;
         logic [2:0] keep;
         keep = snap_data;
         dtr_in = ~dtr_in;
         for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (!snap_valid || snap_data != keep) bad++;
         end
         chk("R7 held while stalled", bad, 0);
      end
      rts_in = ~rts_in;
      snap_ready = 1'b1;
      @(negedge clk);
      chk("R7 reissue after release", snap_valid, 1);
      chk("R2 R7 fresh data", snap_data, {ring_in, dtr_in, rts_in});

      finish_run();
   end

endmodule